// File: doc/BRIEF.md
# PCI Target Write Response Controller

This block chooses the answer a bus target gives to each write data phase it is offered. Memory writes are posted into a write FIFO and accepted with no wait states while the FIFO has room. Once the FIFO is full, the target either stops the burst at once with a disconnect that transfers no data, or it holds the phase in wait states for a bounded grace period, according to a hint from the application that more room is about to appear. Configuration writes never touch the application. They are always terminated with data on their single data word.

I/O writes go through a delayed-write scheme. The first I/O write is captured (command, address, data, byte enables), posted into the FIFO and answered with a retry. When the application has drained the FIFO, the stored write is marked complete. The master's repeat of exactly the same write is then terminated with data, which retires the transaction and clears the FIFOs. Any other I/O write in the meantime is retried and leaves the stored copy untouched. The response outputs are combinational in the current phase. The wait-state count and the delayed-write status are registered.

Top module: `pci_twr_ctrl`

## Requirements
- R1: A memory write phase (`dp_kind` = 2'b00) with `fifo_full` low asserts `rsp_accept` and `fifo_push` in the same cycle, with no wait state.
- R2: A memory write phase with `fifo_full` high and `burst_hint` low asserts `rsp_disconnect_nodata` and does not push.
- R3: While `fifo_full` and `burst_hint` stay high, the first WAIT_MAX (default 8) consecutive memory phases get `rsp_wait`. The phase after them gets `rsp_disconnect_nodata`, and the grace count starts again from zero.
- R4: If `fifo_full` drops during the grace period, that phase is accepted. A later full episode again gets the full WAIT_MAX wait states.
- R5: A configuration write phase (`dp_kind` = 2'b10) asserts `rsp_disconnect_data` whatever the FIFO flags are. It does not push, and it does not change `dw_status`.
- R6: In IDLE, an I/O write phase (`dp_kind` = 2'b01) with `fifo_full` low is retried and pushed, and its fields are stored; `dw_status` becomes PENDING. With `fifo_full` high it is retried, not pushed, and the status stays IDLE.
- R7: In PENDING, every I/O write is retried without a push. A cycle with `fifo_empty` high moves the status to COMPLETE on the next cycle.
- R8: In COMPLETE, an I/O write whose command, address, data and byte enables all equal the stored ones asserts `rsp_disconnect_data` and `fifo_clear`, and the status returns to IDLE.
- R9: In COMPLETE, an I/O write that differs in any one field is retried with no clear. The status stays COMPLETE, and the stored values still match the original write afterwards.
- R10: `dw_status` encodes IDLE as 2'b00, PENDING as 2'b01 and COMPLETE as 2'b10, and it is IDLE after reset.
- R11: With `dp_valid` low, or with `dp_kind` = 2'b11, no response, push or clear output is asserted.
- R12: At most one of the five response outputs is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_valid | input | 1 | A write data phase is presented this cycle |
| dp_kind | input | 2 | 00 memory, 01 I/O, 10 configuration, 11 reserved |
| fifo_full | input | 1 | Write FIFO is full |
| fifo_empty | input | 1 | Write FIFO is empty |
| burst_hint | input | 1 | Application expects room soon; allow wait states |
| io_cmd | input | 4 | Bus command of the I/O write |
| io_addr | input | AW | Address of the I/O write |
| io_data | input | DW | Data of the I/O write |
| io_be | input | DW/8 | Byte enables of the I/O write |
| rsp_accept | output | 1 | Data taken with no wait state |
| rsp_wait | output | 1 | Insert a wait state on this phase |
| rsp_disconnect_data | output | 1 | Terminate, transferring this phase's data |
| rsp_disconnect_nodata | output | 1 | Terminate without transferring this phase's data |
| rsp_retry | output | 1 | Retry the transaction |
| fifo_push | output | 1 | Write this phase's data into the FIFO |
| fifo_clear | output | 1 | Clear the address and write FIFOs |
| dw_status | output | 2 | Delayed I/O write status |

## Verification
Two things can happen in the same cycle: the FIFO drains, which promotes a PENDING delayed write, and the master repeats the identical I/O write. The bench presents the matching write in the cycle that `fifo_empty` first rises. It expects a plain retry with no clear in that cycle, COMPLETE on the following cycle, and retirement only on the next repeat. The grace-period counter is also swept at every drain point inside the window, so that acceptance and the counter restart are judged at each position.

// File: rtl/pci_twr_ctrl.sv
module pci_twr_ctrl #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WAIT_MAX = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dp_valid,
  input  logic [1:0]    dp_kind,
  input  logic          fifo_full,
  input  logic          fifo_empty,
  input  logic          burst_hint,
  input  logic [3:0]    io_cmd,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_data,
  input  logic [DW/8-1:0] io_be,
  output logic          rsp_accept,
  output logic          rsp_wait,
  output logic          rsp_disconnect_data,
  output logic          rsp_disconnect_nodata,
  output logic          rsp_retry,
  output logic          fifo_push,
  output logic          fifo_clear,
  output logic [1:0]    dw_status
);
  localparam int CW = $clog2(WAIT_MAX + 1);
  localparam int BW = DW / 8;
  localparam logic [1:0] K_MEM = 2'b00, K_IO = 2'b01, K_CFG = 2'b10;
  localparam logic [1:0] S_IDLE = 2'b00, S_PEND = 2'b01, S_DONE = 2'b10;

  logic [CW-1:0] wcnt;
  logic [1:0]    st;
  logic [3:0]    s_cmd;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;
  logic [BW-1:0] s_be;

  wire mem_ph = dp_valid && dp_kind == K_MEM;
  wire io_ph  = dp_valid && dp_kind == K_IO;
  wire cfg_ph = dp_valid && dp_kind == K_CFG;

  wire io_hit    = io_cmd == s_cmd && io_addr == s_addr && io_data == s_data && io_be == s_be;
  wire mem_hold  = mem_ph && fifo_full && burst_hint && wcnt < CW'(WAIT_MAX);
  wire io_take   = io_ph && st == S_IDLE && !fifo_full;
  wire io_retire = io_ph && st == S_DONE && io_hit;

  assign rsp_accept            = mem_ph && !fifo_full;
  assign rsp_wait              = mem_hold;
  assign rsp_disconnect_nodata = mem_ph && fifo_full && !mem_hold;
  assign rsp_disconnect_data   = cfg_ph || io_retire;
  assign rsp_retry             = io_ph && !io_retire;
  assign fifo_push             = rsp_accept || io_take;
  assign fifo_clear            = io_retire;
  assign dw_status             = st;

  always_ff @(posedge clk) begin
    if (!rst_n) wcnt <= '0;
    else        wcnt <= mem_hold ? wcnt + CW'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else begin
      case (st)
        S_IDLE:  if (io_take) st <= S_PEND;
        S_PEND:  if (fifo_empty) st <= S_DONE;
        S_DONE:  if (io_retire) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_cmd  <= '0;
      s_addr <= '0;
      s_data <= '0;
      s_be   <= '0;
    end else if (io_take) begin
      s_cmd  <= io_cmd;
      s_addr <= io_addr;
      s_data <= io_data;
      s_be   <= io_be;
    end
  end
endmodule

// File: rtl/pci_twr_ctrl_chk.sv
module pci_twr_ctrl_chk #(
  parameter int WAIT_MAX = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dp_valid,
  input logic [1:0] dp_kind,
  input logic       fifo_full,
  input logic       fifo_empty,
  input logic       burst_hint,
  input logic       rsp_accept,
  input logic       rsp_wait,
  input logic       rsp_disconnect_data,
  input logic       rsp_disconnect_nodata,
  input logic       rsp_retry,
  input logic       fifo_push,
  input logic       fifo_clear,
  input logic [1:0] dw_status
);
  int run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= 0;
    else        run <= rsp_wait ? run + 1 : 0;
  end

  wire mem_full = dp_valid && dp_kind == 2'b00 && fifo_full;

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_accept, rsp_wait, rsp_disconnect_data, rsp_disconnect_nodata, rsp_retry})); // R12
  AST_ROOM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && dp_kind == 2'b00 && !fifo_full) |-> (rsp_accept && fifo_push)); // R1
  AST_NOHINT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_full && !burst_hint) |-> (rsp_disconnect_nodata && !fifo_push)); // R2
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wait |-> run < WAIT_MAX); // R3
  AST_WAIT_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_full && run == WAIT_MAX) |-> rsp_disconnect_nodata); // R3
  AST_CFG_DISC: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && dp_kind == 2'b10) |-> (rsp_disconnect_data && !fifo_push)); // R5
  AST_DRAIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_status == 2'b01 && fifo_empty) |=> dw_status == 2'b10); // R7
  AST_RETIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |=> dw_status == 2'b00); // R8
  AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_valid || dp_kind == 2'b11) |-> !(rsp_accept || rsp_wait || rsp_disconnect_data ||
      rsp_disconnect_nodata || rsp_retry || fifo_push || fifo_clear)); // R11
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    dw_status != 2'b11); // R10
endmodule

bind pci_twr_ctrl pci_twr_ctrl_chk #(.WAIT_MAX(WAIT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .dp_valid(dp_valid), .dp_kind(dp_kind),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty), .burst_hint(burst_hint),
  .rsp_accept(rsp_accept), .rsp_wait(rsp_wait),
  .rsp_disconnect_data(rsp_disconnect_data), .rsp_disconnect_nodata(rsp_disconnect_nodata),
  .rsp_retry(rsp_retry), .fifo_push(fifo_push), .fifo_clear(fifo_clear),
  .dw_status(dw_status)
);

// File: tb/pci_twr_ctrl_test.sv
module pci_twr_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WMAX = 8;
  localparam logic [6:0] NONE = 7'b0000000, ACC = 7'b1000010, WT = 7'b0100000,
                         DD = 7'b0010000, DN = 7'b0001000, RT = 7'b0000100,
                         RTP = 7'b0000110, DDC = 7'b0010001;

  logic clk = 0, rst_n = 0;
  logic dp_valid = 0, fifo_full = 0, fifo_empty = 1, burst_hint = 0;
  logic [1:0] dp_kind = 0;
  logic [3:0] io_cmd = 4'h3;
  logic [31:0] io_addr = 32'h1000_0040, io_data = 32'hA5A5_5A5A;
  logic [3:0] io_be = 4'hF;
  logic rsp_accept, rsp_wait, rsp_dd, rsp_dn, rsp_retry, fifo_push, fifo_clear;
  logic [1:0] dw_status;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pci_twr_ctrl #(.AW(32), .DW(32), .WAIT_MAX(WMAX)) uut (
    .clk(clk), .rst_n(rst_n), .dp_valid(dp_valid), .dp_kind(dp_kind),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .burst_hint(burst_hint),
    .io_cmd(io_cmd), .io_addr(io_addr), .io_data(io_data), .io_be(io_be),
    .rsp_accept(rsp_accept), .rsp_wait(rsp_wait), .rsp_disconnect_data(rsp_dd),
    .rsp_disconnect_nodata(rsp_dn), .rsp_retry(rsp_retry), .fifo_push(fifo_push),
    .fifo_clear(fifo_clear), .dw_status(dw_status));

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic step(logic v, logic [1:0] k, logic full, logic empty, logic hint,
                      logic [6:0] exp, logic [1:0] exp_st, string tag);
    logic [6:0] got;
    @(negedge clk);
    dp_valid = v; dp_kind = k; fifo_full = full; fifo_empty = empty; burst_hint = hint;
    #2;
    got = {rsp_accept, rsp_wait, rsp_dd, rsp_dn, rsp_retry, fifo_push, fifo_clear};
    check(int'(got), int'(exp), tag);
    check(int'($countones(got[6:2]) <= 1), 1, "R12 single response");
    @(posedge clk); #1;
    check(int'(dw_status), int'(exp_st), {tag, " status"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(int'(dw_status), 0, "R10 reset status");
    check(int'({rsp_accept, rsp_wait, rsp_dd, rsp_dn, rsp_retry, fifo_push, fifo_clear}), 0, "R11 reset quiet");
    @(negedge clk); rst_n = 1;

    // R1 R2 R5 R11: sweep kind/full/empty/hint for non-I/O kinds
    for (int k = 0; k < 4; k++) begin
      if (k == 1) continue;
      for (int m = 0; m < 8; m++) begin
        logic f, e, h;
        logic [6:0] exp;
        f = m[0]; e = m[1]; h = m[2];
        if (k == 0) exp = !f ? ACC : (h ? WT : DN);
        else if (k == 2) exp = DD;
        else exp = NONE;
        step(1, 2'(k), f, e, h, exp, 2'b00, k == 0 ? "R1/R2 mem sweep" : (k == 2 ? "R5 cfg sweep" : "R11 reserved kind"));
        step(0, 2'(k), f, e, h, NONE, 2'b00, "R11 idle phase");
      end
    end

    // R3: full grace window, expiry, restart
    for (int i = 0; i < WMAX; i++) step(1, 0, 1, 0, 1, WT, 0, "R3 wait state");
    step(1, 0, 1, 0, 1, DN, 0, "R3 expiry disconnect");
    step(1, 0, 1, 0, 1, WT, 0, "R3 counter restart");
    step(0, 0, 0, 0, 0, NONE, 0, "R11 gap");

    // R4: drain at every point inside the window
    for (int d = 1; d < WMAX; d++) begin
      for (int i = 0; i < d; i++) step(1, 0, 1, 0, 1, WT, 0, "R4 pre-drain wait");
      step(1, 0, 0, 0, 1, ACC, 0, "R4 accept after drain");
      for (int i = 0; i < WMAX; i++) step(1, 0, 1, 0, 1, WT, 0, "R4 fresh window");
      step(1, 0, 1, 0, 1, DN, 0, "R4 fresh expiry");
      step(0, 0, 0, 0, 0, NONE, 0, "R11 gap");
    end

    // R6: delayed I/O capture
    step(1, 1, 1, 0, 0, RT, 0, "R6 full fifo retry no capture");
    step(1, 1, 0, 1, 0, RTP, 1, "R6 capture");
    // R7: pending retries, then drain coinciding with a matching repeat
    step(1, 1, 0, 0, 0, RT, 1, "R7 pending retry");
    step(1, 0, 0, 0, 0, ACC, 1, "R7 mem while pending");
    step(1, 1, 0, 1, 0, RT, 2, "R7 drain same cycle as repeat");
    // R9: one field differs
    for (int f = 0; f < 4; f++) begin
      case (f)
        0: io_cmd  ^= 4'h1;
        1: io_addr ^= 32'h4;
        2: io_data ^= 32'h8000_0000;
        default: io_be ^= 4'h2;
      endcase
      step(1, 1, 0, 1, 0, RT, 2, "R9 mismatch retry");
      io_cmd = 4'h3; io_addr = 32'h1000_0040; io_data = 32'hA5A5_5A5A; io_be = 4'hF;
    end
    step(1, 2, 1, 1, 0, DD, 2, "R5 cfg during complete");
    step(0, 1, 0, 1, 0, NONE, 2, "R11 invalid io");
    // R8: matching repeat retires
    step(1, 1, 0, 1, 0, DDC, 0, "R8 retire");
    step(1, 1, 0, 1, 0, RTP, 1, "R6 recapture after retire");
    step(1, 1, 0, 1, 0, RT, 2, "R7 drain");
    step(1, 1, 0, 1, 0, DDC, 0, "R8 retire again");

    finish_run();
  end
endmodule